// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-memory address for a microprogrammed control unit. It holds the 7-bit control address register and a 7-bit return-address register. Each cycle it takes the condition-select, branch-type and address fields of the current microinstruction, three datapath status flags and four opcode bits. From these it loads the control address register with one of four values: the current address plus one, the address field, the saved return address, or an entry point derived from the opcode.

The control address leaves the block on `carOut` and drives the address of an external 128-word control store. The microinstruction that the store returns for that address is fed back on the field inputs. A taken call saves the address that follows the call in the return register, and a later return resumes there. Only one level of calls is supported.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets `carOut` to 64 (binary 1000000) and clears the return register to 0. This applies at power-up and also in the middle of a run.
- R2: `condSel` picks the branch condition. 00 is always true, 01 is `indirectFlag`, 10 is `signFlag` and 11 is `zeroFlag`.
- R3: With `branchSel`=00 (jump) and the selected condition true, the next `carOut` equals `addrField`.
- R4: With `branchSel`=00 or 01 and the selected condition false, the next `carOut` is the current `carOut` plus one.
- R5: With `branchSel`=01 (call) and the selected condition true, the next `carOut` equals `addrField`, and the return register takes the current `carOut` plus one.
- R6: With `branchSel`=10 (return), the next `carOut` equals the return register, whatever the value of the condition.
- R7: With `branchSel`=11 (map), the next `carOut` is 0 in bit 6, `opcodeBits[3:0]` in bits 5..2, and 00 in bits 1..0.
- R8: The return register keeps its value on every cycle that is not a taken call. This covers a call whose condition is false.
- R9: Incrementing from 127 wraps `carOut` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| condSel | input | 2 | Condition-select field of the microinstruction |
| branchSel | input | 2 | Branch-type field of the microinstruction |
| addrField | input | 7 | Address field of the microinstruction |
| indirectFlag | input | 1 | Indirect bit of the fetched data word |
| signFlag | input | 1 | Sign bit of the accumulator |
| zeroFlag | input | 1 | Accumulator-is-zero flag |
| opcodeBits | input | 4 | Instruction opcode bits used by the map branch |
| carOut | output | 7 | Control address register, drives the control store |

## Verification
The return register is the hardest part to observe, because it has no port of its own. The bench can see its contents only through a later return. Each scenario that might disturb the register therefore ends with a return: a call whose condition is false, jumps, maps, a return whose condition is false, and a reset in the middle of a run. The `carOut` value after that return shows whether the saved address survived or was cleared as required.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SRC_INC = 2'd0,
    SRC_AD  = 2'd1,
    SRC_RET = 2'd2,
    SRC_MAP = 2'd3
  } srcSel_e;

  typedef struct packed {
    srcSel_e srcSel;
    logic    saveRet;
  } seqStrobe_t;

  localparam logic [1:0] BR_JUMP = 2'b00;
  localparam logic [1:0] BR_CALL = 2'b01;
  localparam logic [1:0] BR_RET  = 2'b10;
  localparam logic [1:0] BR_MAP  = 2'b11;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic [1:0] condSel,
  input  logic [1:0] branchSel,
  input  logic       indirectFlag,
  input  logic       signFlag,
  input  logic       zeroFlag,
  output logic       condHit,
  output seqStrobe_t strobes
);
  logic [3:0] condVec;

  assign condVec = {zeroFlag, signFlag, indirectFlag, 1'b1};
  assign condHit = condVec[condSel];

  always_comb begin
    strobes.saveRet = 1'b0;
    strobes.srcSel  = SRC_INC;
    unique case (branchSel)
      BR_JUMP: strobes.srcSel = condHit ? SRC_AD : SRC_INC;
      BR_CALL: begin
        strobes.srcSel  = condHit ? SRC_AD : SRC_INC;
        strobes.saveRet = condHit;
      end
      BR_RET:  strobes.srcSel = SRC_RET;
      default: strobes.srcSel = SRC_MAP;
    endcase
  end
endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobes,
  input  logic [ADDR_W-1:0] addrField,
  input  logic [OPC_W-1:0]  opcodeBits,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr
);
  localparam int LOW_W = ADDR_W - OPC_W - 1;

  logic [ADDR_W-1:0] carPlus;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextCar;

  assign carPlus = car + ADDR_W'(1);
  assign mapAddr = {1'b0, opcodeBits, {LOW_W{1'b0}}};

  always_comb begin
    unique case (strobes.srcSel)
      SRC_AD:  nextCar = addrField;
      SRC_RET: nextCar = sbr;
      SRC_MAP: nextCar = mapAddr;
      default: nextCar = carPlus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= ADDR_W'(RESET_ADDR);
      sbr <= '0;
    end else begin
      car <= nextCar;
      if (strobes.saveRet) sbr <= carPlus;
    end
  end

  // R8
  sbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.saveRet |=> $stable(sbr));

  // R1
  reset_val_chk: assert property (@(posedge clk)
    rst |=> (car == ADDR_W'(RESET_ADDR)) && (sbr == '0));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condSel,
  input  logic [1:0]        branchSel,
  input  logic [ADDR_W-1:0] addrField,
  input  logic              indirectFlag,
  input  logic              signFlag,
  input  logic              zeroFlag,
  input  logic [OPC_W-1:0]  opcodeBits,
  output logic [ADDR_W-1:0] carOut
);
  seqStrobe_t        strobes;
  logic              condHit;
  logic [ADDR_W-1:0] sbr;

  useq_ctrl u_ctrl (
    .condSel(condSel), .branchSel(branchSel), .indirectFlag(indirectFlag),
    .signFlag(signFlag), .zeroFlag(zeroFlag), .condHit(condHit), .strobes(strobes)
  );

  useq_datapath #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .addrField(addrField),
    .opcodeBits(opcodeBits), .car(carOut), .sbr(sbr)
  );

  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (branchSel == BR_JUMP && condHit) |=> carOut == $past(addrField));

  // R4
  not_taken_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!branchSel[1] && !condHit) |=> carOut == $past(carOut) + ADDR_W'(1));

  // R5
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    (branchSel == BR_CALL && condHit) |=> (sbr == $past(carOut) + ADDR_W'(1)) && (carOut == $past(addrField)));

  // R6
  return_chk: assert property (@(posedge clk) disable iff (rst)
    (branchSel == BR_RET) |=> carOut == $past(sbr));

  // R7
  map_chk: assert property (@(posedge clk) disable iff (rst)
    (branchSel == BR_MAP) |=> (carOut[ADDR_W-1] == 1'b0) && (carOut[ADDR_W-2 -: OPC_W] == $past(opcodeBits)));
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] condSel = 2'b00;
  logic [1:0] branchSel = 2'b00;
  logic [6:0] addrField = '0;
  logic       indirectFlag = 1'b0;
  logic       signFlag = 1'b0;
  logic       zeroFlag = 1'b0;
  logic [3:0] opcodeBits = '0;
  logic [6:0] carOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  useq_top dut (
    .clk(clk), .rst(rst), .condSel(condSel), .branchSel(branchSel),
    .addrField(addrField), .indirectFlag(indirectFlag), .signFlag(signFlag),
    .zeroFlag(zeroFlag), .opcodeBits(opcodeBits), .carOut(carOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [6:0] exp);
    checks++;
    if (carOut !== exp) begin
      fails++;
      $display("FAIL %s: carOut=%0d expected=%0d", tag, carOut, exp);
    end
  endtask

  // One microinstruction: drive the fields, clock once, then sample carOut
  task automatic step(input logic [1:0] cd, input logic [1:0] br, input logic [6:0] ad,
                      input logic [2:0] flags, input logic [3:0] opc);
    condSel = cd; branchSel = br; addrField = ad;
    {zeroFlag, signFlag, indirectFlag} = flags;
    opcodeBits = opc;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset car", 7'd64);
    step(2'b00, 2'b10, 7'd0, 3'b000, 4'd0);
    check("R1 sbr cleared (via return)", 7'd0);
  endtask

  task automatic t_jump();
    step(2'b00, 2'b00, 7'd5, 3'b000, 4'd0);
    check("R3 unconditional jump", 7'd5);
    step(2'b01, 2'b00, 7'd20, 3'b110, 4'd0);
    check("R4 R2 indirect=0 increments", 7'd6);
    step(2'b01, 2'b00, 7'd20, 3'b001, 4'd0);
    check("R2 indirect=1 jumps", 7'd20);
    step(2'b10, 2'b00, 7'd40, 3'b101, 4'd0);
    check("R2 sign=0 increments", 7'd21);
    step(2'b10, 2'b00, 7'd40, 3'b010, 4'd0);
    check("R2 sign=1 jumps", 7'd40);
    step(2'b11, 2'b00, 7'd90, 3'b011, 4'd0);
    check("R2 zero=0 increments", 7'd41);
    step(2'b11, 2'b00, 7'd90, 3'b100, 4'd0);
    check("R2 zero=1 jumps", 7'd90);
  endtask

  task automatic t_call();
    step(2'b00, 2'b01, 7'd67, 3'b000, 4'd0);
    check("R5 call taken target", 7'd67);
    step(2'b01, 2'b01, 7'd10, 3'b000, 4'd0);
    check("R4 call not taken increments", 7'd68);
    step(2'b00, 2'b00, 7'd3, 3'b000, 4'd0);
    step(2'b00, 2'b11, 7'd0, 3'b000, 4'hF);
    check("R7 map opcode 1111", 7'd60);
    step(2'b01, 2'b10, 7'd99, 3'b000, 4'd0);
    check("R6 R8 return (cond false) to saved", 7'd91);
    step(2'b00, 2'b10, 7'd0, 3'b000, 4'd0);
    check("R8 return again, unchanged", 7'd91);
  endtask

  task automatic t_map();
    step(2'b00, 2'b11, 7'd0, 3'b000, 4'b1011);
    check("R7 map opcode 1011", 7'd44);
    step(2'b00, 2'b11, 7'd127, 3'b111, 4'b0000);
    check("R7 map opcode 0000", 7'd0);
    step(2'b00, 2'b11, 7'd0, 3'b000, 4'b0001);
    check("R7 map opcode 0001", 7'd4);
  endtask

  task automatic t_wrap();
    step(2'b00, 2'b00, 7'd127, 3'b000, 4'd0);
    check("R3 jump to 127", 7'd127);
    step(2'b11, 2'b00, 7'd50, 3'b000, 4'd0);
    check("R9 wrap to 0", 7'd0);
    step(2'b00, 2'b00, 7'd127, 3'b000, 4'd0);
    step(2'b00, 2'b01, 7'd30, 3'b000, 4'd0);
    check("R5 call from 127", 7'd30);
    step(2'b00, 2'b10, 7'd0, 3'b000, 4'd0);
    check("R9 R5 saved return wraps to 0", 7'd0);
  endtask

  task automatic t_midreset();
    step(2'b00, 2'b00, 7'd12, 3'b000, 4'd0);
    step(2'b00, 2'b01, 7'd100, 3'b000, 4'd0);
    check("R5 call before reset", 7'd100);
    do_reset();
    check("R1 reset mid-run", 7'd64);
    step(2'b00, 2'b10, 7'd0, 3'b000, 4'd0);
    check("R1 sbr cleared mid-run", 7'd0);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #2;
    @(posedge clk); #1;
    t_reset();
    t_jump();
    t_call();
    t_map();
    t_wrap();
    t_midreset();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule